// File: doc/BRIEF.md
# Capture Sample-Rate Pacer with DMA Packing

This block times audio capture from a fast system clock. A fixed divide-by-16 prescaler drives a programmable rate timer. Each time the timer expires, the block strobes the converter to take one sample. The captured bytes are placed into DMA words, either one byte per word or two bytes per word, and the block raises a request for each word. When the host DMA engine reports terminal count together with an acknowledge, the block stops capturing and sets an interrupt status bit.

The rate timer never stops, and it is not reset when capture is switched on. The enable bit only decides whether an expiry leads to a capture. When software turns capture back on for the next buffer, the first new sample therefore falls on the same sample grid as the old ones. The spacing across the buffer boundary is exact, and there is no phase jump that depends on how quickly software reacted.

Software programs the block through a small write port that has two addresses. Address 0 holds the rate value and address 1 holds the control bits. A read strobe returns the control and status bits and clears the sticky status.

Top module: `adc_pace_top`

## Requirements
- R1: After reset is released, counting clock edges from k = 1, a capture strobe can occur only in the cycle that follows edge k where k mod 16 = 15.
- R2: With rate value N, consecutive expiries are 16·(N+2) clock cycles apart.
- R3: Writing a new rate value does not change the period in progress. The new value applies from the next reload.
- R4: `adc_strobe` pulses on an expiry only while control bit 0 (enable) is 1. The timer keeps its phase while capture is disabled and when enable is written again. After enable is set, the first strobe falls on the existing grid and at most one period later.
- R5: With control bit 2 (wide) at 0, every capture raises one request, and `dma_data` is {8'h00, sample}.
- R6: With wide at 1, two captures make one request, and `dma_data` is {second sample, first sample}. A 0→1 write of the enable bit puts the first sample after the write into the low byte.
- R7: `dma_req` stays high until a cycle in which `dma_ack` is high, and it is low in the cycle after that acknowledge.
- R8: If a word is complete while a request is still unacknowledged, the new word is dropped, `dma_data` keeps its value, and status bit 4 (overrun) is set.
- R9: An acknowledge that comes with `dma_tc` high sets status bit 3 (irq status) and clears enable, so capture stops. `irq` is high exactly when irq status and control bit 1 (irq enable) are both 1.
- R10: A cycle with `ctl_rd` high clears the irq status bit and the overrun bit, unless a setting event happens in the same cycle.
- R11: After reset, `ctl_rdata` is 0, `dma_req` and `irq` are low, and no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = rate value, 1 = control |
| cfg_wdata | input | RATE_W | Write data. For control writes: bit 0 enable, bit 1 irq enable, bit 2 wide |
| ctl_rd | input | 1 | Read strobe for control/status; clears the sticky bits |
| ctl_rdata | output | 5 | {overrun, irq status, wide, irq enable, enable} |
| adc_strobe | output | 1 | One-cycle capture strobe; sample taken in the same cycle |
| adc_data | input | SAMP_W | Converter sample |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge |
| dma_tc | input | 1 | Terminal count, valid with acknowledge |
| dma_data | output | 2*SAMP_W | DMA word |
| irq | output | 1 | Interrupt |

## Verification
The bench sweeps several rate values and checks every strobe position and interval. A design with an off-by-one reload would show periods of 16·(N+1) or 16·(N+3). It also places rate rewrites right at an expiry, where a design that loads the new value immediately would shorten the current period. Capture is disabled and re-enabled after a range of delays, and each time the first new strobe is checked against the old grid. A design that restarts the timer on enable would land off the grid. Further tests leave a wide-mode lane half full before a restart, withhold acknowledges to force an overrun, and end buffers with terminal count both with and without irq enable. These catch lane pointers that are not cleared, requests that are overwritten, and interrupts that are not masked.

// File: rtl/adc_pace_pkg.sv
package adc_pace_pkg;
    localparam int CTL_EN   = 0;
    localparam int CTL_IE   = 1;
    localparam int CTL_WIDE = 2;
    localparam int CTL_IRQ  = 3;
    localparam int CTL_OVR  = 4;
    localparam int CTL_W    = 5;

    localparam logic ADDR_RATE = 1'b0;
    localparam logic ADDR_CTL  = 1'b1;

    typedef struct packed {
        logic en;
        logic ie;
        logic wide;
        logic irq_st;
        logic ovr;
    } ctl_t;
endpackage

// File: rtl/pace_prescale.sv
module pace_prescale #(
    parameter int PRE_DIV = 16,
    localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [PW-1:0] ph_d, ph_q;

    always_comb begin
        tick = (ph_q == PW'(PRE_DIV - 1));
        ph_d = tick ? '0 : ph_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end
endmodule

// File: rtl/pace_rate_timer.sv
module pace_rate_timer #(
    parameter int RATE_W = 8,
    localparam int CW = RATE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    output logic              expire
);
    logic [CW-1:0] cnt_d, cnt_q;

    // Reload with rate+1 and count down to 0, giving rate+2 ticks per period.
    always_comb begin
        cnt_d  = cnt_q;
        expire = tick && (cnt_q == '0);
        if (tick) begin
            if (cnt_q == '0) cnt_d = {1'b0, rate} + CW'(1);
            else             cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pace_pack.sv
module pace_pack #(
    parameter int SAMP_W = 8,
    localparam int WORD_W = 2 * SAMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [SAMP_W-1:0] sample,
    input  logic              wide,
    input  logic              lane_clr,
    input  logic              ack,
    input  logic              tc,
    output logic              req,
    output logic [WORD_W-1:0] data,
    output logic              ovr_evt,
    output logic              tc_evt
);
    typedef struct packed {
        logic              req;
        logic [WORD_W-1:0] data;
        logic [SAMP_W-1:0] hold;
        logic              lane;
    } pk_t;

    pk_t d, q;
    logic              ack_ok;
    logic [WORD_W-1:0] word;

    always_comb begin
        d       = q;
        ovr_evt = 1'b0;
        ack_ok  = q.req && ack;
        tc_evt  = ack_ok && tc;
        word    = wide ? {sample, q.hold} : {{SAMP_W{1'b0}}, sample};
        if (ack_ok)   d.req  = 1'b0;
        if (lane_clr) d.lane = 1'b0;
        if (capture) begin
            if (wide && !d.lane) begin
                d.hold = sample;
                d.lane = 1'b1;
            end else begin
                d.lane = 1'b0;
                if (q.req && !ack_ok) begin
                    ovr_evt = 1'b1;
                end else begin
                    d.req  = 1'b1;
                    d.data = word;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req  = q.req;
    assign data = q.data;
endmodule

// File: rtl/adc_pace_top.sv
module adc_pace_top
    import adc_pace_pkg::*;
#(
    parameter int PRE_DIV = 16,
    parameter int RATE_W  = 8,
    parameter int SAMP_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_addr,
    input  logic [RATE_W-1:0]   cfg_wdata,
    input  logic                ctl_rd,
    output logic [CTL_W-1:0]    ctl_rdata,
    output logic                adc_strobe,
    input  logic [SAMP_W-1:0]   adc_data,
    output logic                dma_req,
    input  logic                dma_ack,
    input  logic                dma_tc,
    output logic [2*SAMP_W-1:0] dma_data,
    output logic                irq
);
    typedef struct packed {
        logic [RATE_W-1:0] rate;
        ctl_t              ctl;
    } regs_t;

    regs_t d, q;
    logic  tick, expire, lane_clr, ovr_evt, tc_evt;

    pace_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pace_rate_timer #(.RATE_W(RATE_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .rate   (q.rate),
        .expire (expire)
    );

    assign adc_strobe = expire && q.ctl.en;

    pace_pack #(.SAMP_W(SAMP_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (adc_strobe),
        .sample   (adc_data),
        .wide     (q.ctl.wide),
        .lane_clr (lane_clr),
        .ack      (dma_ack),
        .tc       (dma_tc),
        .req      (dma_req),
        .data     (dma_data),
        .ovr_evt  (ovr_evt),
        .tc_evt   (tc_evt)
    );

    always_comb begin
        d        = q;
        lane_clr = 1'b0;
        if (cfg_we) begin
            if (cfg_addr == ADDR_RATE) begin
                d.rate = cfg_wdata;
            end else begin
                d.ctl.en   = cfg_wdata[CTL_EN];
                d.ctl.ie   = cfg_wdata[CTL_IE];
                d.ctl.wide = cfg_wdata[CTL_WIDE];
                lane_clr   = cfg_wdata[CTL_EN] && !q.ctl.en;
            end
        end
        if (ctl_rd) begin
            d.ctl.irq_st = 1'b0;
            d.ctl.ovr    = 1'b0;
        end
        if (ovr_evt) d.ctl.ovr = 1'b1;
        if (tc_evt) begin
            d.ctl.irq_st = 1'b1;
            d.ctl.en     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        ctl_rdata           = '0;
        ctl_rdata[CTL_EN]   = q.ctl.en;
        ctl_rdata[CTL_IE]   = q.ctl.ie;
        ctl_rdata[CTL_WIDE] = q.ctl.wide;
        ctl_rdata[CTL_IRQ]  = q.ctl.irq_st;
        ctl_rdata[CTL_OVR]  = q.ctl.ovr;
    end

    assign irq = q.ctl.irq_st && q.ctl.ie;
endmodule

// File: rtl/adc_pace_chk.sv
module adc_pace_chk
    import adc_pace_pkg::*;
#(
    parameter int PRE_DIV = 16,
    parameter int SAMP_W  = 8,
    localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ctl_rd,
    input logic [CTL_W-1:0]    ctl_rdata,
    input logic                adc_strobe,
    input logic                dma_req,
    input logic                dma_ack,
    input logic                dma_tc,
    input logic [2*SAMP_W-1:0] dma_data,
    input logic                irq
);
    logic [PW-1:0] phase;
    always_ff @(posedge clk) begin
        if (!rst_n)                         phase <= '0;
        else if (phase == PW'(PRE_DIV - 1)) phase <= '0;
        else                                phase <= phase + 1'b1;
    end

    AST_STROBE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strobe |-> (phase == PW'(PRE_DIV - 1))); // R1
    AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strobe |-> ctl_rdata[CTL_EN]); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> dma_req); // R7
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack) |=> !dma_req); // R7
    AST_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> $stable(dma_data)); // R8
    AST_TC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack && dma_tc) |=> (!ctl_rdata[CTL_EN] && ctl_rdata[CTL_IRQ])); // R9
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (ctl_rdata[CTL_IRQ] && ctl_rdata[CTL_IE])); // R9
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd && !(dma_req && dma_ack && dma_tc)) |=> !ctl_rdata[CTL_IRQ]); // R10
endmodule

bind adc_pace_top adc_pace_chk #(.PRE_DIV(PRE_DIV), .SAMP_W(SAMP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_rd     (ctl_rd),
    .ctl_rdata  (ctl_rdata),
    .adc_strobe (adc_strobe),
    .dma_req    (dma_req),
    .dma_ack    (dma_ack),
    .dma_tc     (dma_tc),
    .dma_data   (dma_data),
    .irq        (irq)
);

// File: tb/sim_adc_pace_top.sv
module sim_adc_pace_top;
    localparam int TCLK  = 10;
    localparam int LIMIT = 150000;
    localparam int NEXP  = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        ctl_rd = 1'b0;
    logic [4:0]  ctl_rdata;
    logic        adc_strobe;
    logic [7:0]  adc_data;
    logic        dma_req;
    logic        dma_ack = 1'b0;
    logic        dma_tc = 1'b0;
    logic [15:0] dma_data;
    logic        irq;

    int cyc = 0;
    int total = 0;
    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] expq [NEXP];
    int widx = 0, ridx = 0, nstrobe = 0, last_t = 0;
    int acks = 0, tc_at = -1;
    int sync_cnt = 0, sync_seen = 0, man_cnt = 0, man_seen = 0;
    bit auto_ack = 1'b1, wide_mode = 1'b0;

    always #(TCLK/2) clk = ~clk;

    adc_pace_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ctl_rd(ctl_rd), .ctl_rdata(ctl_rdata),
        .adc_strobe(adc_strobe), .adc_data(adc_data), .dma_req(dma_req),
        .dma_ack(dma_ack), .dma_tc(dma_tc), .dma_data(dma_data), .irq(irq)
    );

    assign adc_data = 8'((cyc * 29) ^ 165);

    always @(posedge clk) begin
        total <= total + 1;
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Strobe monitor: phase position (R1) and sample log.
    always @(negedge clk) begin
        if (rst_n && adc_strobe) begin
            chk(cyc % 16 == 15, "R1 strobe phase", cyc % 16, 15);
            expq[widx % NEXP] = adc_data;
            widx++;
            nstrobe++;
            last_t = cyc;
        end
    end

    // DMA responder.
    always @(negedge clk) begin
        logic [15:0] ew;
        if (sync_seen != sync_cnt) begin
            ridx = widx;
            sync_seen = sync_cnt;
        end
        if (dma_ack) begin
            dma_ack = 1'b0;
            dma_tc  = 1'b0;
        end else if (rst_n && dma_req && man_seen != man_cnt) begin
            man_seen = man_cnt;
            dma_ack  = 1'b1;
        end else if (rst_n && auto_ack && dma_req) begin
            if (wide_mode) begin
                ew = {expq[(ridx + 1) % NEXP], expq[ridx % NEXP]};
                chk(dma_data == ew, "R6 packed word", dma_data, ew);
                ridx += 2;
            end else begin
                ew = {8'h00, expq[ridx % NEXP]};
                chk(dma_data == ew, "R5 single word", dma_data, ew);
                ridx += 1;
            end
            dma_tc  = (acks + 1 == tc_at);
            dma_ack = 1'b1;
            acks++;
        end
    end

    always @(negedge clk) begin
        if (total > LIMIT) begin
            chk(1'b0, "watchdog", total, LIMIT);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wr(input logic a, input int v);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 8'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(output logic [4:0] v);
        ctl_rd = 1'b1;
        v = ctl_rdata;
        @(negedge clk);
        ctl_rd = 1'b0;
    endtask

    task automatic wait_strobe(output int t, output logic [7:0] s);
        do @(negedge clk); while (!adc_strobe);
        t = cyc;
        s = adc_data;
    endtask

    task automatic drain();
        while (dma_req) @(negedge clk);
        repeat (3) @(negedge clk);
        sync_cnt++;
        @(negedge clk);
    endtask

    initial begin
        int t0, t1, t2, t3, ten, oldr, a0, n0;
        logic [7:0] s, s0;
        logic [4:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctl_rdata == 5'd0, "R11 ctl after reset", ctl_rdata, 0);
        chk(!dma_req, "R11 req after reset", dma_req, 0);
        chk(!irq, "R11 irq after reset", irq, 0);
        repeat (120) @(negedge clk);
        chk(nstrobe == 0, "R11 R4 no strobe while disabled", nstrobe, 0);

        // Rate sweep: period (R2) and deferred rate update (R3).
        wr(1'b1, 1);
        oldr = 0;
        for (int r = 1; r <= 5; r++) begin
            wait_strobe(t0, s);
            wr(1'b0, r);
            wait_strobe(t1, s);
            chk(t1 - t0 == 16 * (oldr + 2), "R3 old period kept", t1 - t0, 16 * (oldr + 2));
            wait_strobe(t2, s);
            chk(t2 - t1 == 16 * (r + 2), "R2 period", t2 - t1, 16 * (r + 2));
            wait_strobe(t3, s);
            chk(t3 - t2 == 16 * (r + 2), "R2 period", t3 - t2, 16 * (r + 2));
            oldr = r;
        end

        // Phase kept across disable/enable (R4). Rate 3 -> 80 cycles.
        wr(1'b0, 3);
        wait_strobe(t0, s);
        wait_strobe(t0, s);
        for (int k = 0; k < 6; k++) begin
            wr(1'b1, 0);
            repeat (7 + 29 * k) @(negedge clk);
            ten = cyc;
            wr(1'b1, 1);
            wait_strobe(t1, s);
            chk((t1 - t0) % 80 == 0, "R4 restart on grid", (t1 - t0) % 80, 0);
            chk(t1 - ten <= 80, "R4 first sample within a period", t1 - ten, 80);
            t0 = t1;
        end
        wr(1'b1, 1);
        wait_strobe(t1, s);
        chk(t1 - t0 == 80, "R4 enable rewrite keeps phase", t1 - t0, 80);

        // Overrun (R7, R8, R10).
        drain();
        auto_ack = 1'b0;
        wait_strobe(t0, s0);
        wait_strobe(t1, s);
        wait_strobe(t2, s);
        @(negedge clk);
        chk(dma_req, "R7 request held", dma_req, 1);
        chk(dma_data == {8'h00, s0}, "R8 first word kept", dma_data, {8'h00, s0});
        rd(v);
        chk(v[4], "R8 overrun set", v[4], 1);
        rd(v);
        chk(!v[4], "R10 overrun cleared by read", v[4], 0);
        man_cnt++;
        repeat (3) @(negedge clk);
        chk(!dma_req, "R7 request released by ack", dma_req, 0);
        sync_cnt++;
        @(negedge clk);
        auto_ack = 1'b1;

        // Wide packing (R6).
        wr(1'b1, 0);
        drain();
        wide_mode = 1'b1;
        a0 = acks;
        wr(1'b1, 5);
        for (int i = 0; i < 6; i++) wait_strobe(t0, s);
        repeat (4) @(negedge clk);
        chk(acks - a0 == 3, "R6 one request per two samples", acks - a0, 3);
        wait_strobe(t0, s);
        wr(1'b1, 4);
        drain();
        wr(1'b1, 5);
        for (int i = 0; i < 4; i++) wait_strobe(t0, s);
        repeat (4) @(negedge clk);
        wr(1'b1, 0);
        drain();
        wide_mode = 1'b0;

        // Terminal count with irq enabled (R9, R10).
        tc_at = acks + 3;
        wr(1'b1, 3);
        for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
        chk(irq, "R9 irq raised at terminal count", irq, 1);
        rd(v);
        chk(v[3] && !v[0], "R9 status set and capture stopped", v, 5'b01010);
        chk(!irq, "R10 irq cleared by read", irq, 0);
        n0 = nstrobe;
        t0 = last_t;
        repeat (300) @(negedge clk);
        chk(nstrobe == n0, "R9 no capture after terminal count", nstrobe - n0, 0);
        drain();
        ten = cyc;
        wr(1'b1, 1);
        wait_strobe(t1, s);
        chk((t1 - t0) % 80 == 0, "R4 next buffer on grid", (t1 - t0) % 80, 0);
        chk(t1 - ten <= 80, "R4 next buffer within a period", t1 - ten, 80);

        // Terminal count with irq masked (R9).
        tc_at = acks + 2;
        for (int i = 0; i < 2000 && ctl_rdata[0]; i++) @(negedge clk);
        @(negedge clk);
        chk(!ctl_rdata[0], "R9 enable cleared", ctl_rdata[0], 0);
        chk(ctl_rdata[3], "R9 status set when masked", ctl_rdata[3], 1);
        chk(!irq, "R9 irq masked", irq, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule